// File: doc/BRIEF.md
# Serial Port Link Bring-Up Supervisor

This block sits on the switch side of a group of serial links and runs the word-level bring-up handshake for every port at once. Each port presents its received 34-bit word (32 data bits plus 2 overhead bits) once per local word clock. When a transceiver sends its wake-up code, the supervisor moves that port into a state where it transmits the alignment word. The port stays there until the word received on the local word boundary is exactly the alignment code. It then moves the port to transmitting the idle word, which tells the far end that its transmit word boundary is correct.

A completion gate watches all ports that the enable mask admits. When every enabled port is in the idle state, the gate raises the interrupt output. On the clock edge where the interrupt rises, it wipes four sticky per-port error vectors: link, transmit, data and cell. External strobes set these vectors. A link-error strobe also sends its port back to the alignment state. A fresh wake-up code on a port that is already synchronized re-runs the handshake for that port alone.

Top module: `link_init_sup`

## Requirements
- R1: While `rst` is high at a clock edge, every port's `tx_sel` becomes 2'b00, `irq` becomes 0 and all four error vectors become zero.
- R2: An enabled port whose received word equals the wake-up code 34'h2_A5A5_5A5A shows `tx_sel` = 2'b01 (send alignment) after the next edge, whatever its previous state.
- R3: A port showing 2'b01 keeps 2'b01 while its received word differs from the alignment code, including when that code arrives rotated by one bit.
- R4: A port showing 2'b01 whose received word equals the alignment code 34'h1_F0C3_3C0F, with no link-error strobe present, shows 2'b10 (send idle) after the next edge. The alignment code on a port showing 2'b00 has no effect.
- R5: A port whose `port_en` bit is low shows 2'b00 after the next edge, ignores its received word and is left out of the completion condition.
- R6: `irq` is high in a cycle exactly when, at the previous edge, at least one port was enabled and every enabled port showed 2'b10.
- R7: A high bit on `err_link`, `err_tx`, `err_data` or `err_cell` sets the matching bit of the corresponding `*_err_q` output at the next edge. That bit then stays set until it is cleared.
- R8: At the edge where `irq` rises, each error vector becomes exactly the error strobes present in that cycle, so earlier bits are cleared and a same-cycle strobe is kept.
- R9: An `err_link` strobe on an enabled port that is not showing 2'b00 returns that port to 2'b01 after the next edge.
- R10: A wake-up code on a port showing 2'b10 moves only that port to 2'b01, and `irq` falls one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local word clock |
| rst | input | 1 | Synchronous active-high reset |
| port_en | input | 16 | Per-port enable mask |
| rx_words | input | 544 | Received words, port i in bits [34i+33:34i] |
| err_link | input | 16 | Per-port link-error strobes |
| err_tx | input | 16 | Per-port transmit-error strobes |
| err_data | input | 16 | Per-port data-error strobes |
| err_cell | input | 16 | Per-port cell-error strobes |
| tx_sel | output | 32 | Per-port transmit word select, port i in bits [2i+1:2i]: 00 quiet, 01 alignment, 10 idle |
| irq | output | 1 | All enabled ports synchronized |
| link_err_q | output | 16 | Sticky link-error vector |
| tx_err_q | output | 16 | Sticky transmit-error vector |
| data_err_q | output | 16 | Sticky data-error vector |
| cell_err_q | output | 16 | Sticky cell-error vector |

## Verification
One port is walked through a scripted series of received words. The series separates the wake-up code, the exact alignment code, a one-bit-rotated alignment code and unrelated words, so it shows that only an exact match on the word boundary advances the handshake. The same series shows that the alignment code is ignored before a wake-up. Multi-port patterns with a partial mask show that the interrupt waits for the last enabled port and ignores disabled ones. A re-request on one port shows that only that port restarts. Error strobes timed on the completion edge separate a clear-wins ordering from a set-wins ordering.

// File: rtl/lis_pkg.sv
package lis_pkg;

    localparam int WORD_W = 34;

    localparam logic [WORD_W-1:0] WAKE_CODE  = 34'h2_A5A5_5A5A;
    localparam logic [WORD_W-1:0] ALIGN_CODE = 34'h1_F0C3_3C0F;

    localparam int NUM_ERR_KIND = 4;

    typedef enum logic [1:0] {
        PS_QUIET = 2'b00,
        PS_ALIGN = 2'b01,
        PS_IDLE  = 2'b10
    } port_state_t;

    typedef enum logic [1:0] {
        EK_LINK = 2'd0,
        EK_TX   = 2'd1,
        EK_DATA = 2'd2,
        EK_CELL = 2'd3
    } err_kind_t;

    typedef struct packed {
        logic wake;
        logic aligned;
    } rx_class_t;

    function automatic rx_class_t classify_word(input logic [WORD_W-1:0] w);
        rx_class_t c;
        c.wake    = (w == WAKE_CODE);
        c.aligned = (w == ALIGN_CODE);
        return c;
    endfunction

endpackage

// File: rtl/lis_port_fsm.sv
module lis_port_fsm
    import lis_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WORD_W-1:0] rx_word,
    input  logic              link_fault,
    output port_state_t       state
);

    rx_class_t   cls;
    port_state_t nxt;

    always_comb begin
        cls = classify_word(rx_word);
        nxt = state;
        if (!en) begin
            nxt = PS_QUIET;
        end else if (cls.wake) begin
            nxt = PS_ALIGN;
        end else if (link_fault && state != PS_QUIET) begin
            nxt = PS_ALIGN;
        end else if (state == PS_ALIGN && cls.aligned) begin
            nxt = PS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PS_QUIET;
        else     state <= nxt;
    end

endmodule

// File: rtl/lis_err_bank.sv
module lis_err_bank #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_strobe,
    input  logic         wipe,
    output logic [N-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (wipe ? '0 : q) | set_strobe;
    end

endmodule

// File: rtl/lis_done_gate.sv
module lis_done_gate #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] en,
    input  logic [N-1:0] synced,
    output logic         irq,
    output logic         wipe
);

    logic all_ok;

    assign all_ok = (&(synced | ~en)) & (|en);
    assign wipe   = all_ok & ~irq;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= all_ok;
    end

endmodule

// File: rtl/link_init_sup.sv
module link_init_sup
    import lis_pkg::*;
#(
    parameter int NPORTS = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NPORTS-1:0]        port_en,
    input  logic [NPORTS*WORD_W-1:0] rx_words,
    input  logic [NPORTS-1:0]        err_link,
    input  logic [NPORTS-1:0]        err_tx,
    input  logic [NPORTS-1:0]        err_data,
    input  logic [NPORTS-1:0]        err_cell,
    output logic [NPORTS*2-1:0]      tx_sel,
    output logic                     irq,
    output logic [NPORTS-1:0]        link_err_q,
    output logic [NPORTS-1:0]        tx_err_q,
    output logic [NPORTS-1:0]        data_err_q,
    output logic [NPORTS-1:0]        cell_err_q
);

    localparam int SEL_W = 2;

    port_state_t                  pstate [NPORTS];
    logic [NPORTS-1:0]            synced;
    logic                         wipe;
    logic [NUM_ERR_KIND-1:0][NPORTS-1:0] err_in;
    logic [NUM_ERR_KIND-1:0][NPORTS-1:0] err_q;

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        lis_port_fsm u_fsm (
            .clk        (clk),
            .rst        (rst),
            .en         (port_en[i]),
            .rx_word    (rx_words[i*WORD_W +: WORD_W]),
            .link_fault (err_link[i]),
            .state      (pstate[i])
        );
        assign synced[i]                 = (pstate[i] == PS_IDLE);
        assign tx_sel[i*SEL_W +: SEL_W]  = pstate[i];
    end

    lis_done_gate #(.N(NPORTS)) u_done (
        .clk    (clk),
        .rst    (rst),
        .en     (port_en),
        .synced (synced),
        .irq    (irq),
        .wipe   (wipe)
    );

    assign err_in[EK_LINK] = err_link;
    assign err_in[EK_TX]   = err_tx;
    assign err_in[EK_DATA] = err_data;
    assign err_in[EK_CELL] = err_cell;

    for (genvar k = 0; k < NUM_ERR_KIND; k++) begin : g_err
        lis_err_bank #(.N(NPORTS)) u_bank (
            .clk        (clk),
            .rst        (rst),
            .set_strobe (err_in[k]),
            .wipe       (wipe),
            .q          (err_q[k])
        );
    end

    assign link_err_q = err_q[EK_LINK];
    assign tx_err_q   = err_q[EK_TX];
    assign data_err_q = err_q[EK_DATA];
    assign cell_err_q = err_q[EK_CELL];

endmodule

// File: rtl/link_init_sup_chk.sv
module link_init_sup_chk
    import lis_pkg::*;
#(
    parameter int N = 16
) (
    input logic                clk,
    input logic                rst,
    input logic [N-1:0]        port_en,
    input logic [N*WORD_W-1:0] rx_words,
    input logic [N-1:0]        err_link,
    input logic [N-1:0]        err_tx,
    input logic [N-1:0]        err_data,
    input logic [N-1:0]        err_cell,
    input logic [N*2-1:0]      tx_sel,
    input logic                irq,
    input logic [N-1:0]        link_err_q,
    input logic [N-1:0]        tx_err_q,
    input logic [N-1:0]        data_err_q,
    input logic [N-1:0]        cell_err_q
);

    logic [N-1:0] ok_vec;
    logic         all_ok;

    for (genvar i = 0; i < N; i++) begin : g_chk
        logic [1:0]        s;
        logic [WORD_W-1:0] w;
        assign s = tx_sel[2*i +: 2];
        assign w = rx_words[i*WORD_W +: WORD_W];
        assign ok_vec[i] = (s == 2'b10) | ~port_en[i];

        AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (rst)
            !port_en[i] |=> s == 2'b00) else $error("disabled port active"); // R5
        AST_WAKE_TO_ALIGN: assert property (@(posedge clk) disable iff (rst)
            port_en[i] && w == WAKE_CODE |=> s == 2'b01) else $error("wake ignored"); // R2
        AST_HOLD_ALIGN: assert property (@(posedge clk) disable iff (rst)
            port_en[i] && s == 2'b01 && w != ALIGN_CODE |=> s == 2'b01) else $error("left align early"); // R3
        AST_ALIGN_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
            port_en[i] && s == 2'b01 && w == ALIGN_CODE && !err_link[i] |=> s == 2'b10) else $error("no idle"); // R4
        AST_LINK_FAULT: assert property (@(posedge clk) disable iff (rst)
            port_en[i] && s != 2'b00 && err_link[i] |=> s == 2'b01) else $error("fault ignored"); // R9
        AST_STICKY: assert property (@(posedge clk) disable iff (rst)
            err_link[i] |=> link_err_q[i]) else $error("error bit lost"); // R7
    end

    assign all_ok = (&ok_vec) & (|port_en);

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (irq == 1'b0 && tx_sel == '0 && link_err_q == '0 && tx_err_q == '0
                 && data_err_q == '0 && cell_err_q == '0)) else $error("reset state"); // R1
    AST_IRQ_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(all_ok)) else $error("spurious irq"); // R6
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        all_ok |=> irq) else $error("missing irq"); // R6
    AST_WIPE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (link_err_q == $past(err_link) && tx_err_q == $past(err_tx)
                        && data_err_q == $past(err_data) && cell_err_q == $past(err_cell)))
        else $error("wipe wrong"); // R8

endmodule

bind link_init_sup link_init_sup_chk #(.N(NPORTS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .port_en    (port_en),
    .rx_words   (rx_words),
    .err_link   (err_link),
    .err_tx     (err_tx),
    .err_data   (err_data),
    .err_cell   (err_cell),
    .tx_sel     (tx_sel),
    .irq        (irq),
    .link_err_q (link_err_q),
    .tx_err_q   (tx_err_q),
    .data_err_q (data_err_q),
    .cell_err_q (cell_err_q)
);

// File: tb/link_init_sup_tb.sv
module link_init_sup_tb;

    localparam int N = 16;
    localparam int W = 34;
    localparam logic [W-1:0] WAKE  = 34'h2_A5A5_5A5A;
    localparam logic [W-1:0] ALGN  = 34'h1_F0C3_3C0F;
    localparam logic [W-1:0] ROTA  = {ALGN[0], ALGN[W-1:1]};
    localparam logic [W-1:0] OTHER = 34'h0_1234_5678;

    // entry: [7] en, [6:5] word kind (0 other,1 wake,2 align,3 rotated align),
    //        [4] link strobe, [3:2] expected tx_sel, [1] expected irq, [0] unused
    localparam int NSTEP = 17;
    localparam logic [7:0] TBL [NSTEP] = '{
        {1'b1, 2'd0, 1'b0, 2'b00, 1'b0, 1'b0},
        {1'b1, 2'd2, 1'b0, 2'b00, 1'b0, 1'b0},
        {1'b1, 2'd1, 1'b0, 2'b01, 1'b0, 1'b0},
        {1'b1, 2'd0, 1'b0, 2'b01, 1'b0, 1'b0},
        {1'b1, 2'd3, 1'b0, 2'b01, 1'b0, 1'b0},
        {1'b1, 2'd2, 1'b0, 2'b10, 1'b0, 1'b0},
        {1'b1, 2'd0, 1'b0, 2'b10, 1'b1, 1'b0},
        {1'b1, 2'd0, 1'b0, 2'b10, 1'b1, 1'b0},
        {1'b1, 2'd1, 1'b0, 2'b01, 1'b1, 1'b0},
        {1'b1, 2'd0, 1'b0, 2'b01, 1'b0, 1'b0},
        {1'b1, 2'd2, 1'b0, 2'b10, 1'b0, 1'b0},
        {1'b1, 2'd0, 1'b0, 2'b10, 1'b1, 1'b0},
        {1'b1, 2'd0, 1'b1, 2'b01, 1'b1, 1'b0},
        {1'b1, 2'd0, 1'b0, 2'b01, 1'b0, 1'b0},
        {1'b0, 2'd2, 1'b0, 2'b00, 1'b0, 1'b0},
        {1'b0, 2'd1, 1'b0, 2'b00, 1'b0, 1'b0},
        {1'b1, 2'd2, 1'b0, 2'b00, 1'b0, 1'b0}
    };

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [N-1:0]   port_en = '0;
    logic [W-1:0]   rx [N];
    logic [N*W-1:0] rx_words;
    logic [N-1:0]   err_link = '0, err_tx = '0, err_data = '0, err_cell = '0;
    logic [N*2-1:0] tx_sel;
    logic           irq;
    logic [N-1:0]   link_err_q, tx_err_q, data_err_q, cell_err_q;

    int checks = 0;
    int bad    = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) rx_words[i*W +: W] = rx[i];
    end

    link_init_sup #(.NPORTS(N)) u_dut (
        .clk(clk), .rst(rst), .port_en(port_en), .rx_words(rx_words),
        .err_link(err_link), .err_tx(err_tx), .err_data(err_data), .err_cell(err_cell),
        .tx_sel(tx_sel), .irq(irq), .link_err_q(link_err_q), .tx_err_q(tx_err_q),
        .data_err_q(data_err_q), .cell_err_q(cell_err_q)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] sel_of(input int p);
        return tx_sel[2*p +: 2];
    endfunction

    function automatic logic [W-1:0] word_of(input logic [1:0] k);
        case (k)
            2'd1:    return WAKE;
            2'd2:    return ALGN;
            2'd3:    return ROTA;
            default: return OTHER;
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) rx[i] = '0;
        rx[0] = WAKE;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 tx_sel", 64'(tx_sel), 64'd0);
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 errs", 64'({link_err_q, tx_err_q, data_err_q, cell_err_q}), 64'd0);
        rst = 1'b0;
        rx[0] = '0;

        // table walk on port 0, other ports disabled (R2 R3 R4 R5 R6 R9 R10)
        for (int s = 0; s < NSTEP; s++) begin
            port_en[0]  = TBL[s][7];
            rx[0]       = word_of(TBL[s][6:5]);
            err_link[0] = TBL[s][4];
            @(negedge clk);
            chk($sformatf("R2/R3/R4/R5/R9/R10 step %0d tx_sel", s), 64'(sel_of(0)), 64'(TBL[s][3:2]));
            chk($sformatf("R6 step %0d irq", s), 64'(irq), 64'(TBL[s][1]));
        end
        err_link = '0;
        rx[0] = '0;

        // multi-port: ports 0..3 enabled, port 4 disabled with wake (R5, R6)
        port_en = 16'h000F;
        for (int i = 0; i < 5; i++) rx[i] = WAKE;
        @(negedge clk);
        for (int i = 0; i < 4; i++) chk($sformatf("R2 port %0d", i), 64'(sel_of(i)), 64'd1);
        chk("R5 disabled port 4", 64'(sel_of(4)), 64'd0);
        rx[0] = ALGN; rx[1] = ALGN; rx[2] = OTHER; rx[3] = ALGN; rx[4] = '0;
        @(negedge clk);
        chk("R3 port 2 waits", 64'(sel_of(2)), 64'd1);
        chk("R4 port 3 idle", 64'(sel_of(3)), 64'd2);
        for (int i = 0; i < 4; i++) rx[i] = '0;
        @(negedge clk);
        chk("R6 irq waits for port 2", 64'(irq), 64'd0);
        rx[2] = ALGN;
        @(negedge clk);
        rx[2] = '0;
        chk("R4 port 2 idle", 64'(sel_of(2)), 64'd2);
        @(negedge clk);
        chk("R6 irq all enabled synced", 64'(irq), 64'd1);

        // re-request on port 1 only (R10)
        rx[1] = WAKE;
        @(negedge clk);
        rx[1] = '0;
        chk("R10 port 1 realigns", 64'(sel_of(1)), 64'd1);
        chk("R10 port 0 kept", 64'(sel_of(0)), 64'd2);
        chk("R10 port 3 kept", 64'(sel_of(3)), 64'd2);
        @(negedge clk);
        chk("R10 irq falls", 64'(irq), 64'd0);

        // sticky error vectors (R7)
        err_tx[5] = 1'b1; err_data[3] = 1'b1; err_cell[15] = 1'b1;
        @(negedge clk);
        err_tx = '0; err_data = '0; err_cell = '0;
        repeat (3) @(negedge clk);
        chk("R7 tx sticky", 64'(tx_err_q), 64'h0020);
        chk("R7 data sticky", 64'(data_err_q), 64'h0008);
        chk("R7 cell sticky", 64'(cell_err_q), 64'h8000);

        // completion edge wipes, same-cycle strobe kept (R8)
        rx[1] = ALGN;
        @(negedge clk);
        rx[1] = '0;
        err_cell[7] = 1'b1;
        @(negedge clk);
        err_cell = '0;
        chk("R8 irq rose", 64'(irq), 64'd1);
        chk("R8 tx wiped", 64'(tx_err_q), 64'd0);
        chk("R8 data wiped", 64'(data_err_q), 64'd0);
        chk("R8 link wiped", 64'(link_err_q), 64'd0);
        chk("R8 cell keeps new strobe", 64'(cell_err_q), 64'h0080);

        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule